// File: doc/BRIEF.md
# Serial Freeze-Enable Loader

This block takes a twelve-bit run/freeze control word from a single serial line and presents it as a parallel set of enables for four groups of clock outputs. The line is sampled on each rising edge of a free-running serial clock. There is no select or framing pin. The line rests high between words. A sampled low level marks the start of a frame. The twelve samples that follow are the data bits, sent least significant first.

The data bits collect in a shadow shift register. The parallel enable register is written once, on the edge that samples the last data bit, so the outputs never show a partly received word. After that edge the receiver is idle again, and it can accept a new start bit on the very next edge. An enable of 1 lets the matching output run and an enable of 0 asks for it to be frozen. Moving these enables into the output clock domain and gating the clocks without glitches are left to the logic that uses them.

Top module: `frz_serial_loader`

## Requirements
- R1: While `rst_n` is low, all twelve enables are 1, and any partly received frame is discarded.
- R2: While the receiver is idle, a sampled high level on `ser_din` has no effect: the enables keep their value and no frame begins.
- R3: A low level sampled while idle is a start bit, and the data bits begin on the next rising edge.
- R4: Each frame holds exactly twelve data bits, one per clock period. A low data bit inside a frame is never taken as a start bit, and the edge after the twelfth data bit can already sample a new start bit.
- R5: The first data bit after the start bit is D0, and the bits go out in order D0 to D11. D0..D3 drive `bank_a_en[0..3]`, D4..D7 drive `bank_b_en[0..3]`, D8..D10 drive `bank_c_en[0..2]` (bank C outputs 1 to 3), and D11 drives `sync_en`.
- R6: Each enable is a copy of its data bit: 0 means freeze and 1 means run.
- R7: All twelve enables change together on the rising edge that samples D11. They hold their value on every other edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ser_clk | input | 1 | Free-running serial clock; data is sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_din | input | 1 | Serial data: start bit (0), then D0..D11 |
| bank_a_en | output | 4 | Run enables for bank A outputs 0..3 |
| bank_b_en | output | 4 | Run enables for bank B outputs 0..3 |
| bank_c_en | output | 3 | Run enables for bank C outputs 1..3 |
| sync_en | output | 1 | Run enable for the sync output |

## Verification
On every cycle, the assertions check the receiver's sequencing and its hold behaviour. An idle high sample leaves the receiver idle, and an idle low sample starts a frame with the bit count at zero. The count never goes past the last bit, a frame ends exactly after its twelfth bit, and the enables keep their value on every edge that does not commit a frame. Some properties can only be shown by the bench's scenarios: the bit-to-output mapping for many patterns, the freeze/run polarity, back-to-back frames with zero idle gap, frames whose data bits are all low, and a reset that arrives in the middle of a frame.

// File: rtl/frz_serial_loader.sv
module frz_serial_loader #(
  parameter int A_W = 4,
  parameter int B_W = 4,
  parameter int C_W = 3
) (
  input  logic           ser_clk,
  input  logic           rst_n,
  input  logic           ser_din,
  output logic [A_W-1:0] bank_a_en,
  output logic [B_W-1:0] bank_b_en,
  output logic [C_W-1:0] bank_c_en,
  output logic           sync_en
);
  localparam int NB   = A_W + B_W + C_W + 1;
  localparam int CW   = $clog2(NB);
  localparam int LAST = NB - 1;

  logic          busy;
  logic [CW-1:0] cnt;
  logic [NB-2:0] shreg;
  logic [NB-1:0] en_q;
  logic          last_bit;

  assign last_bit = busy && (cnt == CW'(LAST));

  always_ff @(posedge ser_clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt   <= '0;
      shreg <= '0;
      en_q  <= '1;
    end else if (!busy) begin
      if (!ser_din) begin
        busy <= 1'b1;
        cnt  <= '0;
      end
    end else if (last_bit) begin
      en_q <= {ser_din, shreg};
      busy <= 1'b0;
      cnt  <= '0;
    end else begin
      shreg <= {ser_din, shreg[NB-2:1]};
      cnt   <= cnt + 1'b1;
    end
  end

  assign bank_a_en = en_q[A_W-1:0];
  assign bank_b_en = en_q[A_W+B_W-1:A_W];
  assign bank_c_en = en_q[A_W+B_W+C_W-1:A_W+B_W];
  assign sync_en   = en_q[NB-1];

  logic [NB-1:0] en_all;
  assign en_all = {sync_en, bank_c_en, bank_b_en, bank_a_en};

  // R2
  idle_high_chk: assert property (@(posedge ser_clk) disable iff (!rst_n)
    (!busy && ser_din) |=> !busy);

  // R3
  start_bit_chk: assert property (@(posedge ser_clk) disable iff (!rst_n)
    (!busy && !ser_din) |=> (busy && cnt == '0));

  // R4
  cnt_bound_chk: assert property (@(posedge ser_clk) disable iff (!rst_n)
    busy |-> (cnt <= CW'(LAST)));

  // R4
  frame_end_chk: assert property (@(posedge ser_clk) disable iff (!rst_n)
    last_bit |=> !busy);

  // R7
  hold_chk: assert property (@(posedge ser_clk) disable iff (!rst_n)
    !last_bit |=> $stable(en_all));
endmodule

// File: tb/frz_serial_loader_tb.sv
module frz_serial_loader_tb;
  logic       ser_clk = 1'b0;
  logic       rst_n   = 1'b0;
  logic       ser_din = 1'b1;
  logic [3:0] bank_a_en;
  logic [3:0] bank_b_en;
  logic [2:0] bank_c_en;
  logic       sync_en;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 ser_clk = ~ser_clk;

  frz_serial_loader u_dut (
    .ser_clk  (ser_clk),
    .rst_n    (rst_n),
    .ser_din  (ser_din),
    .bank_a_en(bank_a_en),
    .bank_b_en(bank_b_en),
    .bank_c_en(bank_c_en),
    .sync_en  (sync_en)
  );

  // {gap[3:0], data[11:0]}; expected enables equal data
  localparam logic [15:0] VEC [8] = '{
    16'h3_A5C, 16'h0_000, 16'h0_FFF, 16'h5_801,
    16'h1_3C7, 16'h0_E18, 16'h7_555, 16'h2_AAA
  };

  logic [11:0] expv = 12'hFFF;

  function automatic logic [11:0] outs();
    return {sync_en, bank_c_en, bank_b_en, bank_a_en};
  endfunction

  task automatic check(input string req, input logic [11:0] got, input logic [11:0] want);
    checks++;
    if (got !== want) begin
      errors++;
      $display("FAIL %s got=%03h exp=%03h", req, got, want);
    end
  endtask

  task automatic send(input int gap, input logic [11:0] d);
    for (int g = 0; g < gap; g++) begin
      @(negedge ser_clk); ser_din = 1'b1;
    end
    @(negedge ser_clk); ser_din = 1'b0;
    for (int i = 0; i < 12; i++) begin
      @(negedge ser_clk);
      if (i == 6) check("R7 partial frame hidden", outs(), expv);
      ser_din = d[i];
    end
    @(posedge ser_clk); #1;
    expv = d;
    check("R5 R6 mapping", outs(), d);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge ser_clk);
    check("R1 reset value", outs(), 12'hFFF);
    rst_n = 1'b1;

    // R2: idle high for a long stretch
    repeat (20) @(negedge ser_clk);
    check("R2 idle ignored", outs(), 12'hFFF);

    for (int v = 0; v < 8; v++) send(int'(VEC[v][15:12]), VEC[v][11:0]);

    // R5: single-bit walks per group
    send(0, 12'hFFE);
    check("R5 bank_a[0] frozen", {11'h0, bank_a_en[0]}, 12'h000);
    send(1, 12'h7FF);
    check("R5 sync frozen", {11'h0, sync_en}, 12'h000);
    send(0, 12'h0F0);
    check("R5 bank_b all run", {8'h0, bank_b_en}, 12'h00F);
    send(2, 12'h700);
    check("R5 bank_c all run", {9'h0, bank_c_en}, 12'h007);

    // R4: all-zero frame then back-to-back frame, then idle
    send(0, 12'h000);
    send(0, 12'h9B6);
    repeat (15) @(negedge ser_clk);
    check("R4 no spurious frame after zeros", outs(), 12'h9B6);

    // R3: a start bit alone, then line high: frame absorbs highs as data
    @(negedge ser_clk); ser_din = 1'b0;
    repeat (12) @(negedge ser_clk) ser_din = 1'b1;
    @(posedge ser_clk); #1;
    expv = 12'hFFF;
    check("R3 start then all-high data", outs(), 12'hFFF);

    // R1: reset mid-frame discards partial data
    send(0, 12'h123);
    @(negedge ser_clk); ser_din = 1'b0;
    repeat (5) @(negedge ser_clk) ser_din = 1'b0;
    rst_n = 1'b0;
    #1;
    check("R1 reset mid-frame", outs(), 12'hFFF);
    ser_din = 1'b1;
    @(negedge ser_clk); rst_n = 1'b1;
    expv = 12'hFFF;
    repeat (14) @(negedge ser_clk);
    check("R1 no leftover frame", outs(), 12'hFFF);
    send(0, 12'h456);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule